// File: doc/BRIEF.md
# Cache Hierarchy Discovery Sequencer

This block learns the geometry of a processor's cache hierarchy without software help. A one-cycle start pulse launches a fixed program of accesses on an ID-register access port. First it fetches the cache type word, the level-ID word and the current cache-select value. It then walks every level up to the point of coherency. At each level it selects the data or unified cache and then the instruction cache, and it reads the size-ID word of each one. After the walk it writes the saved select value back, so the select register holds the value it had before the run.

The size words are stored in a per-level table. A small read port decodes them on demand into line length, associativity, set count, total capacity, and the index and way shifts that set/way maintenance code needs. The two minimum line sizes and the number of walked levels are presented directly. Once the sequence ends, `done` rises and stays high. The table and the summary outputs remain frozen until the next start pulse, which clears the table.

Top module: `cache_geom_discover`

## Requirements
- R1: After reset, `busy`, `done` and `acc_req` are low and every table entry reads as not valid.
- R2: The access port uses the codes `acc_id` 0 = cache type word, 1 = level-ID word, 2 = cache-select register, 3 = size-ID word. `acc_wr` high marks a write. `acc_req`, `acc_wr`, `acc_id` and `acc_wdata` hold steady until the cycle in which `acc_ack` is high, and that cycle completes the access.
- R3: A run starts with three reads: the type word, then the level-ID word, then the select register.
- R4: `imin_line` equals 4 shifted left by type bits [3:0]. `dmin_line` equals 4 shifted left by type bits [19:16].
- R5: `level_count` equals level-ID bits [26:24]. Levels 0 up to `level_count`-1 are walked, and level L takes its 3-bit cache type from level-ID bits [3L+2:3L].
- R6: A level whose cache type is above 4 gets no access and no valid table entry. Its type is still reported on `tbl_ctype`.
- R7: A level with type bit 2 (unified) or bit 1 (data) set is queried before its instruction cache (bit 0). Each size-word read comes right after a select write of (L << 1) OR instruction flag.
- R8: For a stored size word S, the decoded outputs are: line bytes = 16 << S[2:0], ways = S[12:3] + 1, sets = S[27:13] + 1, and size in KB = line × ways × sets / 1024.
- R9: The index shift is S[2:0] + 4. The way shift is the count of leading zeros of the 32-bit value S[12:3]. When that value is zero (one way), the way shift is 32.
- R10: The last access of a run writes the saved select value back. `done` goes high in the next cycle. Afterwards no access occurs, and the table and summary outputs stay unchanged until the next start.
- R11: A start pulse while `busy` is high has no effect on the access sequence or on the results.
- R12: `tbl_lvl` (0-based level) and `tbl_icache` (1 = instruction cache) pick the entry shown on the `tbl_*` outputs. A new start clears all table entries from the previous run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a discovery run |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run complete, results stable |
| acc_req | output | 1 | Access request |
| acc_wr | output | 1 | Access is a write |
| acc_id | output | 2 | Register code of the access |
| acc_wdata | output | 32 | Write data |
| acc_ack | input | 1 | Access completes this cycle |
| acc_rdata | input | 32 | Read data, valid with `acc_ack` |
| imin_line | output | 32 | Smallest instruction line, bytes |
| dmin_line | output | 32 | Smallest data line, bytes |
| level_count | output | 3 | Levels walked |
| tbl_lvl | input | 3 | Table read level |
| tbl_icache | input | 1 | Table read selects instruction cache |
| tbl_valid | output | 1 | Selected entry was queried |
| tbl_ctype | output | 3 | Cache type of the selected level |
| tbl_line_bytes | output | 12 | Line length in bytes |
| tbl_ways | output | 11 | Associativity |
| tbl_sets | output | 16 | Number of sets |
| tbl_size_kb | output | 32 | Capacity in KB |
| tbl_index_shift | output | 4 | Set index shift |
| tbl_way_shift | output | 6 | Way shift |

## Verification
A second start pulse can land in the same cycle in which the port acknowledges an access of an ongoing walk. At that moment the sequencer both moves to its next step and sees a launch request. The bench holds `start` high for several cycles in the middle of a walk, which covers acknowledge cycles. It then judges the logged access sequence against the one the level-ID word calls for, and it checks the decoded table against the model's size words. An extra or restarted sequence shows up as a log mismatch.

// File: rtl/cgd_pkg.sv
package cgd_pkg;

    localparam int WORD_W      = 32;
    localparam int CTYPE_W     = 3;
    localparam int LOC_LSB     = 24;
    localparam int LINE_W      = 12;
    localparam int WAYS_W      = 11;
    localparam int SETS_W      = 16;
    localparam int ISHIFT_W    = 4;
    localparam int WSHIFT_W    = 6;
    localparam logic [2:0] CTYPE_MAX = 3'd4;

    typedef enum logic [1:0] {
        ID_TYPE  = 2'd0,
        ID_LEVEL = 2'd1,
        ID_SEL   = 2'd2,
        ID_SIZE  = 2'd3
    } acc_id_e;

    typedef enum logic [3:0] {
        S_IDLE, S_RD_TYPE, S_RD_LEVEL, S_RD_SEL, S_LEVEL,
        S_WR_SEL, S_RD_SIZE, S_RESTORE, S_DONE
    } seq_state_e;

    typedef struct packed {
        logic [LINE_W-1:0]   line_bytes;
        logic [WAYS_W-1:0]   ways;
        logic [SETS_W-1:0]   sets;
        logic [WORD_W-1:0]   size_kb;
        logic [ISHIFT_W-1:0] index_shift;
        logic [WSHIFT_W-1:0] way_shift;
    } geom_t;

    function automatic logic [WSHIFT_W-1:0] lead_zeros(input logic [WORD_W-1:0] v);
        logic [WSHIFT_W-1:0] n;
        logic                seen;
        n    = '0;
        seen = 1'b0;
        for (int b = WORD_W - 1; b >= 0; b--) begin
            if (!seen) begin
                if (v[b]) seen = 1'b1;
                else      n    = n + 1'b1;
            end
        end
        return n;
    endfunction

    function automatic geom_t decode_size(input logic [WORD_W-1:0] s);
        geom_t       g;
        logic [63:0] prod;
        g.line_bytes  = LINE_W'(16) << s[2:0];
        g.ways        = WAYS_W'(s[12:3]) + 1'b1;
        g.sets        = SETS_W'(s[27:13]) + 1'b1;
        prod          = 64'(g.line_bytes) * 64'(g.ways) * 64'(g.sets);
        g.size_kb     = prod[10 +: WORD_W];
        g.index_shift = ISHIFT_W'(s[2:0]) + ISHIFT_W'(4);
        g.way_shift   = lead_zeros(WORD_W'(s[12:3]));
        return g;
    endfunction

endpackage

// File: rtl/cgd_seq.sv
module cgd_seq
    import cgd_pkg::*;
#(
    parameter int LVL_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              acc_req,
    output logic              acc_wr,
    output logic [1:0]        acc_id,
    output logic [WORD_W-1:0] acc_wdata,
    input  logic              acc_ack,
    input  logic [WORD_W-1:0] acc_rdata,
    output logic [WORD_W-1:0] imin_line,
    output logic [WORD_W-1:0] dmin_line,
    output logic [LVL_W-1:0]  level_count,
    output logic              tbl_clr,
    output logic              tbl_we,
    output logic              ct_we,
    output logic [LVL_W-1:0]  wr_lvl,
    output logic              wr_icache,
    output logic [CTYPE_W-1:0] wr_ctype,
    output logic [WORD_W-1:0] wr_word
);

    seq_state_e        st_q;
    logic [LVL_W-1:0]  lvl_q, loc_q;
    logic [WORD_W-1:0] lvl_sh_q, sel_save_q, type_q;
    logic              ic_q;
    logic              xfer, idle_like;
    logic [CTYPE_W-1:0] ct;

    assign xfer      = acc_req & acc_ack;
    assign ct        = lvl_sh_q[CTYPE_W-1:0];
    assign idle_like = (st_q == S_IDLE) || (st_q == S_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= S_IDLE;
            lvl_q      <= '0;
            loc_q      <= '0;
            lvl_sh_q   <= '0;
            sel_save_q <= '0;
            type_q     <= '0;
            ic_q       <= 1'b0;
        end else begin
            unique case (st_q)
                S_IDLE, S_DONE: if (start) st_q <= S_RD_TYPE;
                S_RD_TYPE: if (xfer) begin
                    type_q <= acc_rdata;
                    st_q   <= S_RD_LEVEL;
                end
                S_RD_LEVEL: if (xfer) begin
                    loc_q    <= acc_rdata[LOC_LSB +: LVL_W];
                    lvl_sh_q <= acc_rdata;
                    lvl_q    <= '0;
                    st_q     <= S_RD_SEL;
                end
                S_RD_SEL: if (xfer) begin
                    sel_save_q <= acc_rdata;
                    st_q       <= S_LEVEL;
                end
                S_LEVEL: begin
                    if (lvl_q == loc_q) begin
                        st_q <= S_RESTORE;
                    end else if (ct > CTYPE_MAX || ct == '0) begin
                        lvl_q    <= lvl_q + 1'b1;
                        lvl_sh_q <= lvl_sh_q >> CTYPE_W;
                    end else begin
                        ic_q <= !(ct[2] || ct[1]);
                        st_q <= S_WR_SEL;
                    end
                end
                S_WR_SEL: if (xfer) st_q <= S_RD_SIZE;
                S_RD_SIZE: if (xfer) begin
                    if (!ic_q && ct[0]) begin
                        ic_q <= 1'b1;
                        st_q <= S_WR_SEL;
                    end else begin
                        lvl_q    <= lvl_q + 1'b1;
                        lvl_sh_q <= lvl_sh_q >> CTYPE_W;
                        st_q     <= S_LEVEL;
                    end
                end
                S_RESTORE: if (xfer) st_q <= S_DONE;
                default: st_q <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        acc_req   = 1'b0;
        acc_wr    = 1'b0;
        acc_id    = ID_TYPE;
        acc_wdata = '0;
        unique case (st_q)
            S_RD_TYPE:  begin acc_req = 1'b1; acc_id = ID_TYPE;  end
            S_RD_LEVEL: begin acc_req = 1'b1; acc_id = ID_LEVEL; end
            S_RD_SEL:   begin acc_req = 1'b1; acc_id = ID_SEL;   end
            S_RD_SIZE:  begin acc_req = 1'b1; acc_id = ID_SIZE;  end
            S_WR_SEL: begin
                acc_req   = 1'b1;
                acc_wr    = 1'b1;
                acc_id    = ID_SEL;
                acc_wdata = WORD_W'({lvl_q, ic_q});
            end
            S_RESTORE: begin
                acc_req   = 1'b1;
                acc_wr    = 1'b1;
                acc_id    = ID_SEL;
                acc_wdata = sel_save_q;
            end
            default: ;
        endcase
    end

    assign busy        = !idle_like;
    assign done        = (st_q == S_DONE);
    assign tbl_clr     = idle_like && start;
    assign tbl_we      = (st_q == S_RD_SIZE) && xfer;
    assign ct_we       = (st_q == S_LEVEL) && (lvl_q != loc_q);
    assign wr_lvl      = lvl_q;
    assign wr_icache   = ic_q;
    assign wr_ctype    = ct;
    assign wr_word     = acc_rdata;
    assign imin_line   = WORD_W'(4) << type_q[3:0];
    assign dmin_line   = WORD_W'(4) << type_q[19:16];
    assign level_count = loc_q;

    // checker state: a select write must precede every size read
    logic sel_armed_q;
    always_ff @(posedge clk) begin
        if (rst)                                     sel_armed_q <= 1'b0;
        else if (xfer && acc_id == ID_SIZE)          sel_armed_q <= 1'b0;
        else if (xfer && st_q == S_WR_SEL)           sel_armed_q <= 1'b1;
    end

    p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
        acc_req && !acc_ack |=> acc_req && $stable(acc_id) && $stable(acc_wr) && $stable(acc_wdata));

    p_sel_before_size_r7: assert property (@(posedge clk) disable iff (rst)
        acc_req && acc_id == ID_SIZE |-> sel_armed_q);

    p_walk_bound_r5: assert property (@(posedge clk) disable iff (rst)
        acc_req && acc_wr && st_q == S_WR_SEL |-> acc_wdata[LVL_W:1] < loc_q);

    p_restore_last_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(xfer && acc_wr && acc_id == ID_SEL && acc_wdata == sel_save_q));

    p_ignore_start_r11: assert property (@(posedge clk) disable iff (rst)
        busy && start && !acc_ack |=> busy);

endmodule

// File: rtl/cgd_table.sv
module cgd_table
    import cgd_pkg::*;
#(
    parameter int LVL_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               we,
    input  logic               ct_we,
    input  logic [LVL_W-1:0]   wr_lvl,
    input  logic               wr_icache,
    input  logic [CTYPE_W-1:0] wr_ctype,
    input  logic [WORD_W-1:0]  wr_word,
    input  logic [LVL_W-1:0]   rd_lvl,
    input  logic               rd_icache,
    output logic               rd_valid,
    output logic [CTYPE_W-1:0] rd_ctype,
    output logic [WORD_W-1:0]  rd_word
);

    localparam int DEPTH = 1 << LVL_W;

    logic [WORD_W-1:0]  word_q  [DEPTH][2];
    logic               valid_q [DEPTH][2];
    logic [CTYPE_W-1:0] ctype_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_lvl
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                ctype_q[g] <= '0;
            end else if (ct_we && wr_lvl == LVL_W'(g)) begin
                ctype_q[g] <= wr_ctype;
            end
        end
        for (genvar k = 0; k < 2; k++) begin : g_kind
            always_ff @(posedge clk) begin
                if (rst || clr) begin
                    word_q[g][k]  <= '0;
                    valid_q[g][k] <= 1'b0;
                end else if (we && wr_lvl == LVL_W'(g) && wr_icache == 1'(k)) begin
                    word_q[g][k]  <= wr_word;
                    valid_q[g][k] <= 1'b1;
                end
            end
        end
    end

    assign rd_valid = valid_q[rd_lvl][rd_icache];
    assign rd_word  = word_q[rd_lvl][rd_icache];
    assign rd_ctype = ctype_q[rd_lvl];

    p_no_write_on_clear_r12: assert property (@(posedge clk) disable iff (rst)
        !(clr && (we || ct_we)));

endmodule

// File: rtl/cgd_decode.sv
module cgd_decode
    import cgd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] word,
    output geom_t             geom
);

    assign geom = decode_size(word);

    p_way_shift_range_r9: assert property (@(posedge clk) disable iff (rst)
        geom.way_shift >= WSHIFT_W'(22) && geom.way_shift <= WSHIFT_W'(32));

    p_index_shift_range_r9: assert property (@(posedge clk) disable iff (rst)
        geom.index_shift >= ISHIFT_W'(4) && geom.index_shift <= ISHIFT_W'(11));

endmodule

// File: rtl/cache_geom_discover.sv
module cache_geom_discover
    import cgd_pkg::*;
#(
    parameter int LVL_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              acc_req,
    output logic              acc_wr,
    output logic [1:0]        acc_id,
    output logic [31:0]       acc_wdata,
    input  logic              acc_ack,
    input  logic [31:0]       acc_rdata,
    output logic [31:0]       imin_line,
    output logic [31:0]       dmin_line,
    output logic [LVL_W-1:0]  level_count,
    input  logic [LVL_W-1:0]  tbl_lvl,
    input  logic              tbl_icache,
    output logic              tbl_valid,
    output logic [2:0]        tbl_ctype,
    output logic [11:0]       tbl_line_bytes,
    output logic [10:0]       tbl_ways,
    output logic [15:0]       tbl_sets,
    output logic [31:0]       tbl_size_kb,
    output logic [3:0]        tbl_index_shift,
    output logic [5:0]        tbl_way_shift
);

    logic               tbl_clr, tbl_we, ct_we, wr_icache;
    logic [LVL_W-1:0]   wr_lvl;
    logic [CTYPE_W-1:0] wr_ctype;
    logic [WORD_W-1:0]  wr_word, rd_word;
    geom_t              geom;

    cgd_seq #(.LVL_W(LVL_W)) u_seq (
        .clk, .rst, .start, .busy, .done,
        .acc_req, .acc_wr, .acc_id, .acc_wdata, .acc_ack, .acc_rdata,
        .imin_line, .dmin_line, .level_count,
        .tbl_clr, .tbl_we, .ct_we, .wr_lvl, .wr_icache, .wr_ctype, .wr_word
    );

    cgd_table #(.LVL_W(LVL_W)) u_table (
        .clk, .rst, .clr(tbl_clr), .we(tbl_we), .ct_we,
        .wr_lvl, .wr_icache, .wr_ctype, .wr_word,
        .rd_lvl(tbl_lvl), .rd_icache(tbl_icache),
        .rd_valid(tbl_valid), .rd_ctype(tbl_ctype), .rd_word
    );

    cgd_decode u_decode (
        .clk, .rst, .word(rd_word), .geom
    );

    assign tbl_line_bytes  = geom.line_bytes;
    assign tbl_ways        = geom.ways;
    assign tbl_sets        = geom.sets;
    assign tbl_size_kb     = geom.size_kb;
    assign tbl_index_shift = geom.index_shift;
    assign tbl_way_shift   = geom.way_shift;

endmodule

// File: tb/cache_geom_discover_tb.sv
module cache_geom_discover_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        busy, done, acc_req, acc_wr, acc_ack;
    logic [1:0]  acc_id;
    logic [31:0] acc_wdata, acc_rdata, imin_line, dmin_line;
    logic [2:0]  level_count, tbl_lvl, tbl_ctype;
    logic        tbl_icache, tbl_valid;
    logic [11:0] tbl_line_bytes;
    logic [10:0] tbl_ways;
    logic [15:0] tbl_sets;
    logic [31:0] tbl_size_kb;
    logic [3:0]  tbl_index_shift;
    logic [5:0]  tbl_way_shift;

    always #4 clk = ~clk;

    cache_geom_discover u_dut (.*);

    int n_chk = 0;
    int n_fail = 0;

    // register model of the port
    logic [31:0] m_type, m_lvl, m_sel;
    logic [31:0] m_size [16];
    logic [34:0] log_q [64];
    int          log_n = 0;
    int          lat = 1;
    int          wait_cnt = 0;
    logic        r2_bad = 1'b0;
    logic        prev_pend = 1'b0;
    logic [34:0] prev_req = '0;

    initial begin
        acc_ack = 1'b0;
        acc_rdata = '0;
        tbl_lvl = '0;
        tbl_icache = 1'b0;
    end

    always @(negedge clk) begin
        if (!rst && prev_pend && (!acc_req || {acc_wr, acc_id, acc_wdata} != prev_req))
            r2_bad = 1'b1;
        prev_pend = acc_req && !acc_ack;
        prev_req  = {acc_wr, acc_id, acc_wdata};
        if (rst || acc_ack) begin
            acc_ack  = 1'b0;
            wait_cnt = 0;
        end else if (acc_req) begin
            if (wait_cnt >= lat) begin
                acc_ack = 1'b1;
                log_q[log_n] = {acc_wr, acc_id, acc_wr ? acc_wdata : 32'h0};
                if (log_n < 63) log_n++;
                case (acc_id)
                    2'd0: acc_rdata = m_type;
                    2'd1: acc_rdata = m_lvl;
                    2'd2: acc_rdata = m_sel;
                    default: acc_rdata = m_size[m_sel[3:0]];
                endcase
                if (acc_wr && acc_id == 2'd2) m_sel = acc_wdata;
                prev_pend = 1'b0;
            end else begin
                wait_cnt++;
            end
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [5:0] exp_lz(input logic [31:0] v);
        logic [5:0] n = 6'd0;
        logic seen = 1'b0;
        for (int b = 31; b >= 0; b--) begin
            if (!seen) begin
                if (v[b]) seen = 1'b1;
                else n++;
            end
        end
        return n;
    endfunction

    task automatic launch(input logic extra_start);
        log_n = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (extra_start) begin
            for (int i = 0; i < 400 && log_n < 4; i++) @(negedge clk);
            start = 1'b1;
            for (int i = 0; i < 7; i++) @(negedge clk);
            start = 1'b0;
        end
        for (int i = 0; i < 3000 && !done; i++) @(negedge clk);
        chk("R10", "done after run", 64'(done), 64'd1);
    endtask

    task automatic check_seq(input logic [31:0] sel0);
        logic [34:0] ex [64];
        int n = 0;
        int loc = m_lvl[26:24];
        ex[n++] = {1'b0, 2'd0, 32'h0};
        ex[n++] = {1'b0, 2'd1, 32'h0};
        ex[n++] = {1'b0, 2'd2, 32'h0};
        for (int l = 0; l < loc; l++) begin
            logic [2:0] ct = 3'(m_lvl >> (3 * l));
            if (ct <= 3'd4) begin
                if (ct[2] || ct[1]) begin
                    ex[n++] = {1'b1, 2'd2, 32'(l << 1)};
                    ex[n++] = {1'b0, 2'd3, 32'h0};
                end
                if (ct[0]) begin
                    ex[n++] = {1'b1, 2'd2, 32'((l << 1) | 1)};
                    ex[n++] = {1'b0, 2'd3, 32'h0};
                end
            end
        end
        ex[n++] = {1'b1, 2'd2, sel0};
        chk("R3 R6 R7", "access count", 64'(log_n), 64'(n));
        for (int i = 0; i < n && i < log_n; i++)
            chk(i < 3 ? "R3" : (i == n - 1 ? "R10" : "R7"), "access entry", 64'(log_q[i]), 64'(ex[i]));
    endtask

    task automatic check_table();
        int loc = m_lvl[26:24];
        chk("R4", "imin_line", 64'(imin_line), 64'(32'd4 << m_type[3:0]));
        chk("R4", "dmin_line", 64'(dmin_line), 64'(32'd4 << m_type[19:16]));
        chk("R5", "level_count", 64'(level_count), 64'(loc));
        for (int l = 0; l < 8; l++) begin
            for (int k = 0; k < 2; k++) begin
                logic [2:0]  ct = (l < loc) ? 3'(m_lvl >> (3 * l)) : 3'd0;
                logic        v  = (l < loc) && ct <= 3'd4 && (k == 1 ? ct[0] : (ct[2] || ct[1]));
                logic [31:0] s  = m_size[(l << 1) | k];
                logic [63:0] line = 64'd16 << s[2:0];
                logic [63:0] ways = 64'(s[12:3]) + 1;
                logic [63:0] sets = 64'(s[27:13]) + 1;
                tbl_lvl = 3'(l);
                tbl_icache = 1'(k);
                #1;
                chk("R12", "ctype", 64'(tbl_ctype), 64'(ct));
                chk(ct > 3'd4 ? "R6" : "R12", "valid", 64'(tbl_valid), 64'(v));
                if (v) begin
                    chk("R8", "line", 64'(tbl_line_bytes), line);
                    chk("R8", "ways", 64'(tbl_ways), ways);
                    chk("R8", "sets", 64'(tbl_sets), sets);
                    chk("R8", "size_kb", 64'(tbl_size_kb), (line * ways * sets) >> 10);
                    chk("R9", "index shift", 64'(tbl_index_shift), 64'(s[2:0]) + 4);
                    chk("R9", "way shift", 64'(tbl_way_shift), 64'(exp_lz(32'(s[12:3]))));
                end
            end
        end
    endtask

    task automatic cfg_basic();
        m_type = (32'd4 << 16) | 32'd3;
        m_lvl  = (32'd2 << 24) | (32'd4 << 3) | 32'd3;
        m_sel  = 32'h5;
        for (int i = 0; i < 16; i++) m_size[i] = 32'(i * 32'h1111) & 32'h0fff_ffff;
        m_size[0] = (32'd127 << 13) | (32'd3 << 3) | 32'd1;
        m_size[1] = (32'd255 << 13) | (32'd1 << 3) | 32'd1;
        m_size[2] = (32'd1023 << 13) | (32'd7 << 3) | 32'd2;
    endtask

    task automatic t_reset();
        chk("R1", "busy", 64'(busy), 64'd0);
        chk("R1", "done", 64'(done), 64'd0);
        chk("R1", "acc_req", 64'(acc_req), 64'd0);
        tbl_lvl = 3'd0; tbl_icache = 1'b0; #1;
        chk("R1", "valid", 64'(tbl_valid), 64'd0);
    endtask

    task automatic t_basic();
        lat = 2;
        r2_bad = 1'b0;
        cfg_basic();
        launch(1'b0);
        check_seq(32'h5);
        chk("R10", "select restored", 64'(m_sel), 64'h5);
        chk("R2", "request held until ack", 64'(r2_bad), 64'd0);
        check_table();
    endtask

    task automatic t_reserved();
        lat = 0;
        m_type = (32'd2 << 16) | 32'd6;
        m_lvl  = (32'd3 << 24) | (32'd2 << 6) | (32'd5 << 3) | 32'd1;
        m_sel  = 32'h2;
        launch(1'b0);
        check_seq(32'h2);
        check_table();
    endtask

    task automatic t_one_way();
        lat = 1;
        m_type = 32'h000f_000f;
        m_lvl  = (32'd1 << 24) | 32'd3;
        m_sel  = 32'h0;
        m_size[0] = (32'd32767 << 13) | 32'd7;
        m_size[1] = (32'd0 << 13) | (32'd1023 << 3);
        launch(1'b0);
        check_seq(32'h0);
        check_table();
        tbl_lvl = 3'd0; tbl_icache = 1'b0; #1;
        chk("R9", "one-way shift", 64'(tbl_way_shift), 64'd32);
        tbl_icache = 1'b1; #1;
        chk("R9", "max-way shift", 64'(tbl_way_shift), 64'd22);
    endtask

    task automatic t_start_busy();
        lat = 1;
        cfg_basic();
        launch(1'b1);
        check_seq(32'h5);
        check_table();
    endtask

    task automatic t_hold();
        logic [31:0] kb0;
        tbl_lvl = 3'd1; tbl_icache = 1'b0; #1;
        kb0 = tbl_size_kb;
        m_size[2] = 32'h0;
        m_lvl = 32'h0;
        m_type = 32'h0;
        for (int i = 0; i < 20; i++) @(negedge clk);
        chk("R10", "done held", 64'(done), 64'd1);
        chk("R10", "no access after done", 64'(acc_req), 64'd0);
        chk("R10", "table stable", 64'(tbl_size_kb), 64'(kb0));
        chk("R10", "imin stable", 64'(imin_line), 64'd32);
        chk("R10", "level_count stable", 64'(level_count), 64'd2);
    endtask

    initial begin
        cfg_basic();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_reserved();
        t_one_way();
        t_start_busy();
        t_hold();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule